// File: doc/BRIEF.md
# Bidirectional Port with Change Interrupt

An eight-pin general purpose I/O port controlled through a small register bus. Software sets each pin's direction, writes an output latch that drives the output pins, and reads the pin levels through a two-flop synchronizer. A global active-low control turns on weak pull-ups, but only on pins configured as inputs. Some pins come up in an analog mode in which their digital read value is forced to zero.

The upper pins (bits 7 to 4 by default) feed a change detector. Each input-configured upper pin is compared with a snapshot of the port value. The snapshot is loaded on every read or write access to the port register. Any difference sets a sticky flag, and the flag keeps being set for as long as the difference remains. To clear it, software first touches the port register to end the mismatch, then writes a zero to the flag bit at least one cycle later. The flag also leaves the block as a level wake request.

Register map, selected by `addr`:
- 0 is the port. A read returns the pin levels. A write loads the output latch.
- 1 is the output latch. It reads back the latched value.
- 2 is the direction register, where 1 means input.
- 3 is control: bit 0 is the change flag, bit 1 is the pull-up disable (active low enable), bit 2 is the analog select.

Top module: `gpio_chg_port`

## Requirements
- R1: A direction bit of 1 makes its pin an input, with `pin_oe` low. A bit of 0 raises `pin_oe` for that pin, and that pin then drives its `pin_do` latch bit.
- R2: Writing address 0 or address 1 loads the output latch, which drives `pin_do` from the next cycle. Reading address 1 returns the latch, not the pin level.
- R3: Reading address 0 returns `pin_in` as it was two rising edges earlier. While control bit 2 is 1, the analog pins (bits 4, 1 and 0) read as 0.
- R4: Only bits 7 to 4 with a direction bit of 1 take part in change detection. Each is compared with the port value captured on the last access to address 0.
- R5: `chg_flag` goes to 1 in the cycle after a mismatch exists. It stays at 1 while the mismatch lasts, and otherwise until it is cleared.
- R6: A write to address 3 with bit 0 equal to 0 clears the flag, unless a mismatch is present in that cycle. A write with bit 0 equal to 1 leaves the flag unchanged.
- R7: `pull_en[i]` is 1 exactly when control bit 1 is 0 and direction bit i is 1.
- R8: After reset, the registers hold these values: direction is all ones, the latch is 0, control bit 1 is 1 (pull-ups off), control bit 2 is 1 (analog on), and the flag is 0.
- R9: `wake_req` equals `chg_flag` at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 2 | Register select |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| wdata | input | W | Write data |
| rdata | output | W | Read data for `addr` |
| pin_in | input | W | Pin levels from the pads |
| pin_oe | output | W | Per-pin output enable |
| pin_do | output | W | Per-pin output data |
| pull_en | output | W | Per-pin weak pull-up enable |
| chg_flag | output | 1 | Sticky change flag |
| wake_req | output | 1 | Level wake request |

## Verification
The bench builds the block with its defaults: eight pins, the change group starting at bit 4, and the analog mask on bits 4, 1 and 0. With these defaults both the masked analog pin inside the change group (bit 4) and the unmasked upper pins can be reached. Random pin levels, direction values and register accesses are mixed together, so that output-configured pins, analog masking and snapshot refreshes all interact with the change flag. Directed cases cover two situations: a clear that arrives while the mismatch persists, and a clear that arrives one cycle after a port read.

// File: rtl/gpio_chg_port.sv
module gpio_chg_port #(
  parameter int W = 8,
  parameter int CHG_LO = 4,
  parameter logic [W-1:0] ANA_MASK = 8'h13
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   addr,
  input  logic         wr_en,
  input  logic         rd_en,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] pin_oe,
  output logic [W-1:0] pin_do,
  output logic [W-1:0] pull_en,
  output logic         chg_flag,
  output logic         wake_req
);
  localparam logic [W-1:0] LOW_ONES = W'((1 << CHG_LO) - 1);
  localparam logic [W-1:0] CHG_MASK = ~LOW_ONES;

  logic [W-1:0] sync1, sync2, dir, lat, snap, pin_val;
  logic         pu_n, ana, flag, mismatch, port_acc, flag_clr;

  assign pin_val  = sync2 & ~({W{ana}} & ANA_MASK);
  assign port_acc = (rd_en || wr_en) && addr == 2'd0;
  assign flag_clr = wr_en && addr == 2'd3 && !wdata[0];
  assign mismatch = |((pin_val ^ snap) & dir & CHG_MASK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
    end else begin
      sync1 <= pin_in;
      sync2 <= sync1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir  <= '1;
      lat  <= '0;
      pu_n <= 1'b1;
      ana  <= 1'b1;
    end else if (wr_en) begin
      case (addr)
        2'd0, 2'd1: lat <= wdata;
        2'd2: dir <= wdata;
        default: begin
          pu_n <= wdata[1];
          ana  <= wdata[2];
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap <= '0;
      flag <= 1'b0;
    end else begin
      if (port_acc) snap <= pin_val;
      flag <= mismatch || (flag && !flag_clr);
    end
  end

  always_comb begin
    case (addr)
      2'd0: rdata = pin_val;
      2'd1: rdata = lat;
      2'd2: rdata = dir;
      default: begin
        rdata = '0;
        rdata[2:0] = {ana, pu_n, flag};
      end
    endcase
  end

  assign pin_oe   = ~dir;
  assign pin_do   = lat;
  assign pull_en  = dir & {W{~pu_n}};
  assign chg_flag = flag;
  assign wake_req = flag;
endmodule

module gpio_chg_port_chk #(parameter int W = 8) (
  input logic         clk,
  input logic         rst_n,
  input logic [1:0]   addr,
  input logic         wr_en,
  input logic [W-1:0] wdata,
  input logic [W-1:0] pin_oe,
  input logic [W-1:0] pin_do,
  input logic [W-1:0] pull_en,
  input logic         chg_flag,
  input logic         wake_req,
  input logic         mismatch
);
  AST_DIR_OE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd2) |=> (pin_oe == ~$past(wdata))); // R1
  AST_LAT_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr <= 2'd1) |=> (pin_do == $past(wdata))); // R2
  AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    mismatch |=> chg_flag); // R5
  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (chg_flag && !(wr_en && addr == 2'd3 && !wdata[0])) |=> chg_flag); // R5
  AST_FLAG_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd3 && !wdata[0] && !mismatch) |=> !chg_flag); // R6
  AST_PULL_INPUT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (pull_en & pin_oe) == '0); // R7
  AST_WAKE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req == chg_flag); // R9
endmodule

bind gpio_chg_port gpio_chg_port_chk #(.W(W)) u_chk (.*);

// File: tb/test_gpio_chg_port.sv
`timescale 1ns/1ps
module test_gpio_chg_port;
  logic clk = 0, rst_n = 0;
  logic [1:0] addr = 0;
  logic wr_en = 0, rd_en = 0;
  logic [7:0] wdata = 0, rdata, pin_in = 0, pin_oe, pin_do, pull_en;
  logic chg_flag, wake_req;
  int errors = 0, checks = 0;

  logic [7:0] m_dir = 8'hFF, m_lat = 0, m_snap = 0, m_pins = 0;
  logic m_pun = 1, m_ana = 1, m_flag = 0;

  always #2.5 clk = ~clk;

  gpio_chg_port i_gpio_chg_port (.clk, .rst_n, .addr, .wr_en, .rd_en, .wdata, .rdata,
    .pin_in, .pin_oe, .pin_do, .pull_en, .chg_flag, .wake_req);

  function automatic logic [7:0] pv();
    return m_pins & ~(m_ana ? 8'h13 : 8'h00);
  endfunction
  function automatic logic mm();
    return |((pv() ^ m_snap) & m_dir & 8'hF0);
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cycle(logic [1:0] a, logic w, logic r, logic [7:0] d);
    @(negedge clk);
    addr = a; wr_en = w; rd_en = r; wdata = d;
    @(negedge clk);
    wr_en = 0; rd_en = 0;
  endtask

  // apply one access to the model, mirroring the R2/R4/R5/R6 rules
  task automatic op(logic [1:0] a, logic w, logic [7:0] d);
    logic pre;
    pre = mm();
    cycle(a, w, !w, d);
    if (w && a == 3) m_flag = pre | (m_flag & d[0]);
    else m_flag = m_flag | pre;
    if (a == 0) m_snap = pv();
    if (w) case (a)
      0, 1: m_lat = d;
      2: m_dir = d;
      default: begin m_pun = d[1]; m_ana = d[2]; end
    endcase
    @(negedge clk);
    m_flag = m_flag | mm();
  endtask

  task automatic set_pins(logic [7:0] p);
    logic pre;
    pre = mm();
    @(negedge clk); pin_in = p;
    repeat (3) @(negedge clk);
    m_pins = p;
    m_flag = m_flag | pre | mm();
  endtask

  task automatic check_all(string tag);
    chk({tag, " R1 oe"}, pin_oe, ~m_dir);
    chk({tag, " R1 do"}, pin_do, m_lat);
    chk({tag, " R7 pull"}, pull_en, m_dir & {8{~m_pun}});
    chk({tag, " R5 flag"}, {7'b0, chg_flag}, {7'b0, m_flag});
    chk({tag, " R9 wake"}, {7'b0, wake_req}, {7'b0, m_flag});
    for (int a = 0; a < 4; a++) begin
      addr = 2'(a); #0.1;
      case (a)
        0: chk({tag, " R3 port"}, rdata, pv());
        1: chk({tag, " R2 lat"}, rdata, m_lat);
        2: chk({tag, " R1 dir"}, rdata, m_dir);
        default: chk({tag, " R8 ctrl"}, rdata, {5'b0, m_ana, m_pun, m_flag});
      endcase
    end
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check_all("R8 reset");

    // R3: analog bits read zero; R2 latch readback differs from pins
    set_pins(8'hFF);
    check_all("R3 analog");
    op(3, 1, 8'h00);          // analog off, pull-ups on
    op(0, 0, 0);
    check_all("R3 digital");
    op(1, 1, 8'hA5);
    set_pins(8'h00);
    check_all("R2 lat vs pin");

    // R6: clear with mismatch still present keeps flag
    op(0, 0, 0);
    op(3, 1, 8'h00);
    set_pins(8'h80);
    op(3, 1, 8'h00);
    chk("R6 clear blocked by mismatch", {7'b0, chg_flag}, 8'd1);
    op(0, 0, 0);              // port read ends mismatch
    op(3, 1, 8'h01);          // writing 1 does not clear
    chk("R6 write one keeps flag", {7'b0, chg_flag}, 8'd1);
    op(3, 1, 8'h00);
    chk("R6 clear after port read", {7'b0, chg_flag}, 8'd0);

    // R4: output-configured upper pin and lower pins are ignored
    op(2, 1, 8'h7F);
    set_pins(8'h0F);
    chk("R4 output pin and low pins masked", {7'b0, chg_flag}, 8'd0);
    op(2, 1, 8'hFF);
    chk("R4 input pin mismatches", {7'b0, chg_flag}, 8'd1);
    check_all("R4 directed");

    for (int i = 0; i < 400; i++) begin
      int k = $urandom_range(0, 5);
      if (k == 0) set_pins(8'($urandom));
      else op(2'($urandom), 1'($urandom), 8'($urandom));
      check_all("rand");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule